// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Split-Half Bit Timing

This block turns bytes into frames on a serial line that rests high. Each frame has a low start bit, then eight data bits with the least significant bit first, then one high stop bit. The length of every bit is set by a period input, counted in system clock cycles. The period may be any value from 4 upward, odd values included. Each bit is timed as two consecutive half intervals. When the period is odd, one half is one clock longer than the other, so every bit lasts exactly the programmed number of clocks.

The producer offers a byte with a valid/ready handshake. One holding register sits in front of the shifter. While a frame is on the line, the next byte can wait there, and it goes out straight after the current stop bit with no idle gap. The period is captured when a frame starts, so it can be rewritten at any time without harming the byte in flight. A busy output shows whether any byte is still waiting or being sent.

Top module: `uart_dither_tx`

## Requirements
- R1: A frame is one start bit at 0, then the eight data bits least significant bit first, then one stop bit at 1. Each bit holds the line for exactly Pe clocks, where Pe is the effective period captured at the start of the frame.
- R2: When the period P is odd and at least 4, each bit lasts exactly P clocks. Its two halves are floor(P/2) and floor(P/2)+1 clocks long.
- R3: When the period P is even and at least 4, each bit lasts exactly P clocks, made of two halves of P/2 clocks each.
- R4: A period value below 4 (0 to 3) is treated as 4. As a result, the line never holds a level for fewer than 4 clocks.
- R5: After reset, tx_line is 1, busy is 0 and in_ready is 1. Whenever busy is 0, tx_line is 1.
- R6: in_ready is 1 exactly when the holding register is empty. A byte is accepted on a rising edge where in_valid and in_ready are both 1, and in_ready is 0 in the following cycle.
- R7: A byte waiting in the holding register starts its frame on the same edge that ends the previous stop bit, with no idle clock between frames. The holding register then accepts another byte on the next edge.
- R8: The period input is sampled only on the edge that starts a frame. A change during a frame does not alter that frame's timing, and the new value applies to the next frame.
- R9: When the transmitter is idle, the start bit begins on the rising edge that follows the edge accepting the byte.
- R10: busy rises on the edge that accepts a byte. It stays 1 until the edge that ends the last pending stop bit, and on that edge tx_line is 1 and busy falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | DATA_W (8) | Byte offered for transmission |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | Holding register is empty and can take a byte |
| bit_period | input | PER_W (16) | Bit length in clock cycles; values below 4 are treated as 4 |
| tx_line | output | 1 | Serial output, idles high |
| busy | output | 1 | A byte is waiting or being sent |

## Verification
The hardest case to reach from the ports is a full holding register while the shifter is busy. This is the only moment the handshake stalls and the moment the zero-gap hand-over between frames happens. The stimulus reaches it by offering each next byte as soon as in_ready returns. Every stream of two or more bytes therefore keeps the register occupied across each stop-bit boundary, and the acceptance cycles are compared with the arithmetic spacing of 10·Pe. Periods 1 to 21 are swept, together with odd and even large values. A run of all 256 byte values at an odd period and a mid-frame period rewrite cover the timing and sampling rules.

// File: rtl/uart_dither_pkg.sv
// Package: shared constants and types for the split-half serial transmitter.
// Assumes nothing beyond IEEE 1800-2017 package support.
package uart_dither_pkg;

    // Shortest bit length accepted; smaller requests are raised to this.
    localparam int MIN_PERIOD = 4;

    // Which half of the current bit the timer is counting.
    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } half_e;

endpackage

// File: rtl/utx_hold_reg.sv
// Module: single-entry holding register in front of the shifter.
// Takes a byte with a valid/ready handshake and offers it to the framer.
// Assumes take is asserted only while full is high.
module utx_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              take,
    output logic [DATA_W-1:0] out_data,
    output logic              full
);

    logic accept;

    // Handshake: room exists only when the slot is empty.
    always_comb begin
        in_ready = ~full;
        accept   = in_valid & ~full;
    end

    // Slot occupancy and contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full     <= 1'b0;
            out_data <= '0;
        end else if (accept) begin
            full     <= 1'b1;
            out_data <= in_data;
        end else if (take) begin
            full     <= 1'b0;
        end
    end

endmodule

// File: rtl/utx_half_timer.sv
// Module: bit timer built from two half intervals.
// On load it captures the clamped period. While run is high it counts one
// half of floor(P/2) clocks and one of P-floor(P/2) clocks, then pulses
// bit_end in the last clock of the bit. LONG_FIRST picks which half is the
// longer one when P is odd. Assumes load and run come from the framer.
module utx_half_timer
    import uart_dither_pkg::*;
#(
    parameter int PER_W      = 16,
    parameter bit LONG_FIRST = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [PER_W-1:0] period_in,
    output logic             bit_end
);

    localparam logic [PER_W-1:0] PER_MIN = PER_W'(MIN_PERIOD);

    logic [PER_W-1:0] per_c;      // clamped incoming period
    logic [PER_W-1:0] per_q;      // period captured for this frame
    logic [PER_W-1:0] short_len;
    logic [PER_W-1:0] long_len;
    logic [PER_W-1:0] len_a;      // first half length, current frame
    logic [PER_W-1:0] len_b;      // second half length, current frame
    logic [PER_W-1:0] first_new;  // first half length, incoming period
    logic [PER_W-1:0] cnt;
    half_e            ph;

    // Clamp the request and split the captured period into halves.
    always_comb begin
        per_c     = (period_in < PER_MIN) ? PER_MIN : period_in;
        short_len = per_q >> 1;
        long_len  = per_q - short_len;
    end

    // Half ordering variant chosen by parameter.
    generate
        if (LONG_FIRST) begin : g_long_first
            assign len_a     = long_len;
            assign len_b     = short_len;
            assign first_new = per_c - (per_c >> 1);
        end else begin : g_short_first
            assign len_a     = short_len;
            assign len_b     = long_len;
            assign first_new = per_c >> 1;
        end
    endgenerate

    // Down-counter stepping through first and second halves of each bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= PER_MIN;
            cnt   <= '0;
            ph    <= PH_FIRST;
        end else if (load) begin
            per_q <= per_c;
            cnt   <= first_new - 1'b1;
            ph    <= PH_FIRST;
        end else if (run) begin
            if (cnt == '0) begin
                if (ph == PH_FIRST) begin
                    ph  <= PH_SECOND;
                    cnt <= len_b - 1'b1;
                end else begin
                    ph  <= PH_FIRST;
                    cnt <= len_a - 1'b1;
                end
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // Last clock of the second half closes the bit.
    always_comb bit_end = run && (ph == PH_SECOND) && (cnt == '0);

endmodule

// File: rtl/utx_framer.sv
// Module: frame sequencer and output register.
// On load it drives the start bit, then shifts data LSB first and a stop
// bit, advancing on each bit_end. last_bit marks the stop bit so that the
// top can chain the next frame on the same edge. Assumes load is never
// asserted mid-frame except together with bit_end on the stop bit.
module utx_framer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              bit_end,
    output logic              tx,
    output logic              active,
    output logic              last_bit
);

    localparam int FRAME_BITS = DATA_W + 2;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);

    logic [DATA_W:0]    sh;   // bits still to send after the current one
    logic [IDX_W-1:0]   idx;

    // Stop bit is the final index of the frame.
    always_comb last_bit = (idx == IDX_LAST);

    // Bit sequencing and registered line output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx     <= 1'b1;
            active <= 1'b0;
            sh     <= '1;
            idx    <= '0;
        end else if (load) begin
            tx     <= 1'b0;
            active <= 1'b1;
            sh     <= {1'b1, load_data};
            idx    <= '0;
        end else if (bit_end) begin
            if (last_bit) begin
                tx     <= 1'b1;
                active <= 1'b0;
            end else begin
                tx  <= sh[0];
                sh  <= {1'b1, sh[DATA_W:1]};
                idx <= idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/uart_dither_tx.sv
// Module: top of the split-half serial transmitter.
// Joins the holding register, framer and bit timer. A held byte is
// loaded when the framer is idle or on the edge ending a stop bit.
// Assumes a single clock domain and a synchronous active-low reset.
module uart_dither_tx #(
    parameter int DATA_W = 8,
    parameter int PER_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PER_W-1:0]  bit_period,
    output logic              tx_line,
    output logic              busy
);

    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              active;
    logic              last_bit;
    logic              bit_end;
    logic              load;

    // Start a frame when a byte waits and the line is free or freeing.
    always_comb begin
        load = hold_full && (!active || (bit_end && last_bit));
        busy = active || hold_full;
    end

    utx_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (in_data),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .take     (load),
        .out_data (hold_data),
        .full     (hold_full)
    );

    utx_framer #(.DATA_W(DATA_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (hold_data),
        .bit_end   (bit_end),
        .tx        (tx_line),
        .active    (active),
        .last_bit  (last_bit)
    );

    utx_half_timer #(.PER_W(PER_W), .LONG_FIRST(1'b0)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .run       (active),
        .period_in (bit_period),
        .bit_end   (bit_end)
    );

endmodule

// File: rtl/uart_dither_tx_chk.sv
// Module: property checker for uart_dither_tx, attached with bind.
// Observes ports only; keeps a run-length counter for the line.
module uart_dither_tx_chk
    import uart_dither_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PER_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] in_data,
    input logic              in_valid,
    input logic              in_ready,
    input logic [PER_W-1:0]  bit_period,
    input logic              tx_line,
    input logic              busy
);

    localparam int RUN_W = 8;
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    logic [RUN_W-1:0] run_len;
    logic             prev_tx;

    // Length of the current constant-level run on the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_tx <= 1'b1;
            run_len <= RUN_MAX;
        end else begin
            prev_tx <= tx_line;
            if (tx_line != prev_tx)   run_len <= 8'd1;
            else if (run_len != RUN_MAX) run_len <= run_len + 1'b1;
        end
    end

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_line); // R5

    AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready); // R6

    AST_START_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> !tx_line); // R9

    AST_MIN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_line != prev_tx) |-> (run_len >= RUN_W'(MIN_PERIOD))); // R4

    AST_STOP_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(tx_line) && tx_line)); // R10

endmodule

bind uart_dither_tx uart_dither_tx_chk #(.DATA_W(DATA_W), .PER_W(PER_W)) u_chk (.*);

// File: tb/sim_uart_dither_tx.sv
// Bench: sweeps periods and byte values, predicting every line cycle.
module sim_uart_dither_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] bit_period = 16'd8;
    logic        tx_line;
    logic        busy;

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    uart_dither_tx u0 (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .bit_period(bit_period), .tx_line(tx_line), .busy(busy)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] qb [0:255];
    int acc [0:255];
    int nq = 0;
    int pq = 8;
    bit chg = 1'b0;
    string note = "";

    task automatic check(input bit ok, input string tag, input int act, input int exp, input string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int eff(input int p);
        return (p < 4) ? 4 : p;
    endfunction

    function automatic string ptag(input int p);
        if (p < 4) return "R1 R4";
        if (p % 2 == 1) return "R1 R2";
        return "R1 R3";
    endfunction

    // Push nq bytes as fast as in_ready allows and check every line cycle.
    task automatic run_stream();
        int pe;
        pe = eff(pq);
        bit_period = 16'(pq);
        fork
            begin : push
                for (int k = 0; k < nq; k++) begin
                    while (!in_ready) @(negedge clk);
                    in_data  = qb[k];
                    in_valid = 1'b1;
                    @(negedge clk);
                    acc[k]   = cyc;
                    in_valid = 1'b0;
                    check(!in_ready, "R6", int'(in_ready), 0, "ready after accept");
                    if (k > 0)
                        check(acc[k] == acc[0] + 2 + (k - 1) * 10 * pe, "R7",
                              acc[k] - acc[0], 2 + (k - 1) * 10 * pe, "accept spacing");
                    if (chg && k == 0) begin
                        repeat (5) @(negedge clk);
                        bit_period = 16'(pq + 6);
                    end
                end
            end
            begin : mon
                while (!busy) @(negedge clk);
                check(tx_line == 1'b1, "R9", int'(tx_line), 1, "line on accept cycle");
                for (int f = 0; f < nq; f++) begin
                    bit   ok;
                    int   bad_t;
                    logic bad_v;
                    logic bad_e;
                    ok = 1'b1; bad_t = -1; bad_v = 1'b0; bad_e = 1'b0;
                    for (int t = 0; t < 10 * pe; t++) begin
                        int   b;
                        logic e;
                        @(negedge clk);
                        b = t / pe;
                        e = (b == 0) ? 1'b0 : (b == 9) ? 1'b1 : qb[f][b - 1];
                        if ((tx_line !== e || busy !== 1'b1) && ok) begin
                            ok = 1'b0; bad_t = t; bad_v = tx_line; bad_e = e;
                        end
                    end
                    check(ok, {ptag(pq), note}, int'(bad_v), int'(bad_e),
                          $sformatf("frame %0d byte %02h P=%0d offset %0d", f, qb[f], pq, bad_t));
                end
                @(negedge clk);
                check(tx_line == 1'b1 && !busy, "R10", int'({tx_line, busy}), 2, "idle after last stop");
            end
        join
    endtask

    initial begin : watchdog
        wait (cyc >= 150000);
        n_fail++;
        $display("FAIL R1 watchdog: actual %0d expected below %0d cycles", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_line == 1'b1, "R5", int'(tx_line), 1, "line after reset");
        check(busy == 1'b0, "R5", int'(busy), 0, "busy after reset");
        check(in_ready == 1'b1, "R5 R6", int'(in_ready), 1, "ready after reset");

        // Period sweep including clamped values, two chained bytes each.
        for (int p = 1; p <= 21; p++) begin
            nq = 2; pq = p;
            qb[0] = 8'(p * 37 + 5);
            qb[1] = ~qb[0];
            run_stream();
            repeat (3) @(negedge clk);
        end

        // Every byte value back to back at an odd period.
        nq = 256; pq = 5;
        for (int k = 0; k < 256; k++) qb[k] = 8'(k);
        run_stream();
        repeat (2) @(negedge clk);

        // Large periods, odd and even.
        nq = 2; pq = 201; qb[0] = 8'h5A; qb[1] = 8'h81;
        run_stream();
        nq = 1; pq = 173; qb[0] = 8'hC3;
        run_stream();
        nq = 1; pq = 200; qb[0] = 8'h3C;
        run_stream();
        repeat (2) @(negedge clk);

        // Period rewritten mid-frame, then the new value used next frame (R8).
        note = " R8";
        nq = 1; pq = 9; chg = 1'b1; qb[0] = 8'hA5;
        run_stream();
        chg = 1'b0;
        check(bit_period == 16'd15, "R8", int'(bit_period), 15, "period input rewritten");
        pq = 15; qb[0] = 8'h96;
        run_stream();
        note = "";

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule